// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous static RAM of 16K words by 4 bits. The host posts one read or write at a time with a request strobe. The controller turns it into a pin-level cycle: a 14-bit address, active-low chip select, write enable and output enable. The 4-bit shared data bus is split into three signals: a driven value, a drive enable and a sampled input. When the cycle ends, the controller raises a one-cycle acknowledge. A read also returns the sampled nibble with a valid strobe.

Every phase length is a parameter counted in clock cycles. The read hold is the largest of the read cycle time, the address access time and the output-enable access time. Writes are strobed with write enable while output enable stays high, so the RAM never drives the bus during a write. In that case the write pulse only has to cover the larger of the minimum pulse width and the data setup time. A write has one setup cycle before the strobe and one recovery cycle after it. The address never moves while chip select is low.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high and in the cycle after it, chip select, write enable and output enable are high, the data drive enable is low, and acknowledge and read-valid are low.
- R2: In the cycle after acknowledge, before a new request is taken, chip select, write enable and output enable are high and the data drive enable is low.
- R3: A read holds chip select and output enable low, with write enable high, for exactly RDL = max(TRC, TAA, TOE) cycles. These start in the cycle after the request is taken. The data drive enable stays low for the whole read.
- R4: A read returns the bus value sampled in its last active cycle on `rdata`. In the next cycle, `rvalid` and `ack` are high together for one cycle, RDL+1 cycles after the request is taken.
- R5: A write holds chip select low for WPL+2 cycles, where WPL = max(TWP, TDW). In the first and last of those cycles write enable is high. In the WPL cycles between them, write enable is low. Acknowledge follows in the next cycle, WPL+3 cycles after the request is taken.
- R6: Output enable stays high for the whole of every write.
- R7: In a write, the data drive enable is high for exactly WPL+1 cycles: the write-enable-low cycles and the recovery cycle. During those cycles the driven value equals the host write data. The drive enable is never high while the RAM could be driving, that is, with chip select and output enable low and write enable high.
- R8: The address output takes the host address when a request is taken. It does not change while chip select is low.
- R9: A request is taken only when the controller is idle and acknowledge is low. A request that is still held during the acknowledge cycle starts no new cycle. Acknowledge is never high for two cycles in a row.
- R10: A write never raises `rvalid` and leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request strobe, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address |
| req_wdata | input | 4 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Read data |
| rvalid | output | 1 | Read data valid, with ack |
| sram_addr | output | 14 | RAM address pins |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | 4 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | 4 | Value sampled from the data bus |

## Verification
The bench places the request on a falling edge and then counts falling edges until acknowledge appears. A read must acknowledge on the RDL+1-th falling edge and a write on the WPL+3-th. Along the way, the bench tallies the cycles with each strobe low and with the data drive enable high, and compares each tally with its exact figure. The bench's RAM model returns unknown data until the read has been held for max(TAA, TOE) cycles. A read sampled a cycle early therefore fails its data compare. Requests held into the acknowledge cycle are checked on the next falling edge, where chip select must still be high.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int ADDR_W = 14;
    localparam int DATA_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_WRECOV
    } ctl_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int read_len(input int trc, input int taa, input int toe);
        return max2(trc, max2(taa, toe));
    endfunction

    // With OE low the strobe must also cover the RAM's turn-off time.
    function automatic int write_len(input bit oe_low, input int twp,
                                     input int twhz, input int tdw);
        return oe_low ? max2(twp, twhz + tdw) : max2(twp, tdw);
    endfunction

    function automatic int cnt_width(input int n);
        return $clog2(n + 1) + 1;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_LEN = 3,
    parameter int WR_LEN = 3,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             accept_we,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output pin_ctl_t         pins,
    output logic             finish,
    output logic             finish_rd,
    output logic             idle
);
    ctl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        finish    = 1'b0;
        finish_rd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (accept_we) begin
                        state_d = ST_WSETUP;
                    end else begin
                        state_d  = ST_READ;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_LEN - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    state_d   = ST_IDLE;
                    finish    = 1'b1;
                    finish_rd = 1'b1;
                end
            end
            ST_WSETUP: begin
                state_d  = ST_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_LEN - 1);
            end
            ST_WPULSE: begin
                if (tmr_zero) state_d = ST_WRECOV;
            end
            ST_WRECOV: begin
                state_d = ST_IDLE;
                finish  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin levels decode from the registered state only.
    always_comb begin
        pins = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        unique case (state_q)
            ST_READ:   begin pins.cs_n = 1'b0; pins.oe_n = 1'b0; end
            ST_WSETUP: begin pins.cs_n = 1'b0; end
            ST_WPULSE: begin pins.cs_n = 1'b0; pins.we_n = 1'b0; pins.dq_oe = 1'b1; end
            ST_WRECOV: begin pins.cs_n = 1'b0; pins.dq_oe = 1'b1; end
            default: ;
        endcase
    end

    assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int TRC  = 3,
    parameter int TAA  = 3,
    parameter int TOE  = 2,
    parameter int TWP  = 2,
    parameter int TWHZ = 1,
    parameter int TDW  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int RD_LEN = read_len(TRC, TAA, TOE);
    localparam int WR_LEN = write_len(1'b0, TWP, TWHZ, TDW);
    localparam int CNT_W  = cnt_width(max2(RD_LEN, WR_LEN));

    host_req_t         cap_q;
    logic              ack_q, rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept, idle, finish, finish_rd;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    pin_ctl_t          pins;

    assign accept = req && idle && !ack_q;

    sram_ctl_seq #(
        .RD_LEN (RD_LEN),
        .WR_LEN (WR_LEN),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .accept_we (req_we),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .pins      (pins),
        .finish    (finish),
        .finish_rd (finish_rd),
        .idle      (idle)
    );

    sram_ctl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= '0;
            ack_q    <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            ack_q    <= finish;
            rvalid_q <= finish_rd;
            if (accept)    cap_q   <= '{we: req_we, addr: req_addr, data: req_wdata};
            if (finish_rd) rdata_q <= sram_dq_in;
        end
    end

    assign ack         = ack_q;
    assign rvalid      = rvalid_q;
    assign rdata       = rdata_q;
    assign sram_addr   = cap_q.addr;
    assign sram_dq_out = cap_q.data;
    assign sram_cs_n   = pins.cs_n;
    assign sram_we_n   = pins.we_n;
    assign sram_oe_n   = pins.oe_n;
    assign sram_dq_oe  = pins.dq_oe;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
    import sram_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic              rvalid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !ack && !rvalid)); // R1

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_cs_n && sram_we_n && !sram_dq_oe)); // R3

    AST_RVALID_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> ack); // R4

    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_cs_n); // R5

    AST_WE_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> $past(!sram_cs_n)); // R5

    AST_NO_DRIVE_OE_LOW: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (sram_oe_n && !sram_cs_n)); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && !$past(sram_cs_n)) |-> $stable(sram_addr)); // R8

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R9
endmodule

bind sram_ctl sram_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack        (ack),
    .rvalid     (rvalid),
    .sram_addr  (sram_addr),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TRC = 3, TAA = 3, TOE = 2, TWP = 2, TWHZ = 1, TDW = 3;
    localparam int RDL = (TRC > TAA ? (TRC > TOE ? TRC : TOE) : (TAA > TOE ? TAA : TOE));
    localparam int WPL = (TWP > TDW) ? TWP : TDW;
    localparam int ACC = (TAA > TOE) ? TAA : TOE;
    localparam int WATCHDOG = 20000;
    localparam int NVEC = 9;

    // {we, addr[13:0], data[3:0]}: data is write data or expected read data
    localparam logic [18:0] VECS [0:NVEC-1] = '{
        {1'b1, 14'h0005, 4'hA},
        {1'b1, 14'h3FFF, 4'h5},
        {1'b1, 14'h0000, 4'hF},
        {1'b0, 14'h0005, 4'hA},
        {1'b0, 14'h3FFF, 4'h5},
        {1'b0, 14'h0000, 4'hF},
        {1'b1, 14'h0005, 4'h3},
        {1'b0, 14'h0005, 4'h3},
        {1'b0, 14'h3FFF, 4'h5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [13:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        ack, rvalid, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [3:0]  rdata, sram_dq_out, sram_dq_in;
    logic [13:0] sram_addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int fights = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctl #(.TRC(TRC), .TAA(TAA), .TOE(TOE), .TWP(TWP), .TWHZ(TWHZ), .TDW(TDW)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .rvalid(rvalid),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    // RAM model: 16 cells indexed by the low address nibble; unknown until access time elapses.
    logic [3:0] mem [0:15];
    int age;
    wire ram_reading = !sram_cs_n && !sram_oe_n && sram_we_n;
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 4'h0;
            age <= 0;
        end else begin
            if (!sram_cs_n && !sram_we_n && sram_dq_oe) mem[sram_addr[3:0]] <= sram_dq_out;
            age <= ram_reading ? age + 1 : 0;
        end
    end
    assign sram_dq_in = (ram_reading && (age + 1 >= ACC)) ? mem[sram_addr[3:0]] : 4'bxxxx;

    always @(negedge clk) if (sram_dq_oe && ram_reading) fights++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog (R all) cycles=%0d expected<%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic run_txn(input logic we, input logic [13:0] a, input logic [3:0] d,
                           input bit hold, output logic [3:0] got, output int lat,
                           output int cs_c, output int we_c, output int oe_c,
                           output int dq_c, output int rv, output int bad_a,
                           output int bad_d, output int first_we, output int last_we);
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        lat = 0; cs_c = 0; we_c = 0; oe_c = 0; dq_c = 0; rv = 0;
        bad_a = 0; bad_d = 0; first_we = 0; last_we = 0; got = 4'h0;
        while (lat < 60) begin
            @(negedge clk);
            lat++;
            if (!sram_cs_n) begin
                cs_c++;
                if (sram_addr != a) bad_a++;
                if (cs_c == 1) first_we = sram_we_n;
                last_we = sram_we_n;
            end
            if (!sram_we_n) we_c++;
            if (!sram_oe_n) oe_c++;
            if (sram_dq_oe) begin
                dq_c++;
                if (sram_dq_out != d) bad_d++;
            end
            if (ack) begin
                got = rdata;
                rv  = rvalid;
                break;
            end
        end
        if (!hold) req = 1'b0;
    endtask

    initial begin
        logic [3:0] got;
        logic [3:0] last_rd;
        int lat, cs_c, we_c, oe_c, dq_c, rv, bad_a, bad_d, fwe, lwe;

        // R1: reset state
        repeat (3) @(negedge clk);
        check({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack, rvalid} == 6'b111000,
              "R1 reset pins", {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack, rvalid}, 6'b111000);
        rst = 1'b0;
        @(negedge clk);
        check({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack, rvalid} == 6'b111000,
              "R1 after reset", {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack, rvalid}, 6'b111000);
        last_rd = rdata;

        for (int v = 0; v < NVEC; v++) begin
            logic        vwe;
            logic [13:0] va;
            logic [3:0]  vd;
            {vwe, va, vd} = VECS[v];
            run_txn(vwe, va, vd, 1'b0, got, lat, cs_c, we_c, oe_c, dq_c, rv, bad_a, bad_d, fwe, lwe);
            check(bad_a == 0, "R8 address held", bad_a, 0);
            if (vwe) begin
                check(lat == WPL + 3, "R5 write ack latency", lat, WPL + 3);
                check(cs_c == WPL + 2, "R5 write cs low cycles", cs_c, WPL + 2);
                check(we_c == WPL, "R5 we pulse cycles", we_c, WPL);
                check(fwe == 1 && lwe == 1, "R5 setup/recovery we high", {fwe[0], lwe[0]}, 2'b11);
                check(oe_c == 0, "R6 oe low during write", oe_c, 0);
                check(dq_c == WPL + 1, "R7 drive cycles", dq_c, WPL + 1);
                check(bad_d == 0, "R7 driven data", bad_d, 0);
                check(rv == 0, "R10 rvalid on write", rv, 0);
                check(got == last_rd, "R10 rdata kept", got, last_rd);
            end else begin
                check(lat == RDL + 1, "R4 read ack latency", lat, RDL + 1);
                check(cs_c == RDL && oe_c == RDL, "R3 read strobe cycles", cs_c * 16 + oe_c, RDL * 17);
                check(we_c == 0 && dq_c == 0, "R3 no write/drive in read", we_c + dq_c, 0);
                check(got === vd, "R4 read data", got, vd);
                check(rv == 1, "R4 rvalid with ack", rv, 1);
                last_rd = got;
            end
            @(negedge clk);
            check({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack} == 5'b11100,
                  "R2 idle pins", {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack}, 5'b11100);
        end

        // R9: request held into the ack cycle starts nothing
        run_txn(1'b0, 14'h0000, 4'hF, 1'b1, got, lat, cs_c, we_c, oe_c, dq_c, rv, bad_a, bad_d, fwe, lwe);
        check(got === 4'hF, "R4 read before hold test", got, 4'hF);
        @(negedge clk);
        check(sram_cs_n == 1'b1 && ack == 1'b0, "R9 held req not taken", {sram_cs_n, ack}, 2'b10);
        req = 1'b0;
        @(negedge clk);
        check(sram_cs_n == 1'b1 && ack == 1'b0, "R9 still idle", {sram_cs_n, ack}, 2'b10);

        // R7: no drive while the RAM could drive
        check(fights == 0, "R7 bus conflict cycles", fights, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule